// File: doc/BRIEF.md
# Packed Lane Left Shifter

This unit takes a 64-bit or 128-bit vector and splits it into independent lanes of 16, 32 or 64 bits. It shifts every lane left by one shared count, fills the vacated low bits with zeros and discards the bits that leave the top of each lane. The count comes from an 8-bit immediate or from a 64-bit register value. The whole count is compared against the lane limit. A count past the last bit position of a lane clears the entire result; it does not wrap.

The unit is a two-stage pipeline with a valid strobe and no back-pressure. Stage one selects the count, compares it against the limit and captures the operand. Stage two forms the shifted lanes for every lane size, picks one and registers it onto the output. A new operation can enter on every cycle. No condition or status output exists.

Top module: `lane_shl_unit`

## Requirements
- R1: `laneSel` picks the lane size: 2'b00 gives 16-bit lanes, 2'b01 gives 32-bit lanes, and 2'b10 or 2'b11 gives 64-bit lanes. Lane i occupies bits [i*L +: L], and every lane is shifted left by the same count.
- R2: The vacated low-order bits of each lane are zero. Bits shifted out of the top of a lane are dropped and never reach the lane above it.
- R3: When the count is greater than L-1 (15, 31 or 63), the whole `dataOut` is zero.
- R4: With `useImm`=0, all 64 bits of `regCount` form the count, and the limit test is not truncated. For example, 2^32+1 clears the result in every lane mode.
- R5: With `useImm`=1, the count is `immCount` zero-extended, and `regCount` has no effect on the result.
- R6: With `wideMode`=0, only `dataIn[63:0]` is processed and `dataOut[127:64]` is zero. With `wideMode`=1, all 128 bits are processed.
- R7: `outValid` is high exactly two rising edges after the edge that samples `inValid` high, and `dataOut` carries that operation's result in the same cycle. One operation per cycle is accepted.
- R8: When no operation completes, `dataOut` keeps the last result.
- R9: Synchronous active-high `rst` clears `outValid` and `dataOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation strobe |
| dataIn | input | 128 | Operand vector |
| laneSel | input | 2 | Lane size select |
| wideMode | input | 1 | 1 = 128-bit operand, 0 = 64-bit operand |
| useImm | input | 1 | 1 = immediate count, 0 = register count |
| immCount | input | 8 | Immediate shift count |
| regCount | input | 64 | Register shift count |
| outValid | output | 1 | Result strobe |
| dataOut | output | 128 | Shifted vector |

## Verification
A wrong stage-one limit flag or count field shows up at the ports two edges after the operation. It appears as a non-zero word where all zeros were due, or as lanes shifted by the wrong amount. The boundary counts L-1, L, 255 and values above 2^32 are swept in every lane and width mode against an arithmetic per-lane model. A lost or extra valid bit, or a wrong lane select, shows up in the first back-to-back stream that mixes modes. Each output in that stream is checked against the operation issued two cycles earlier.

// File: rtl/lane_shl_pkg.sv
package lane_shl_pkg;

  typedef enum logic [1:0] {
    LANE16  = 2'b00,
    LANE32  = 2'b01,
    LANE64  = 2'b10,
    LANE64X = 2'b11
  } laneSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load1;
    logic load2;
  } pipeCtl_t;

endpackage

// File: rtl/lane_shl_ctrl.sv
module lane_shl_ctrl
  import lane_shl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output pipeCtl_t ctl,
  output logic     outValid
);

  logic v1;
  logic v2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
    end
  end

  always_comb begin
    ctl.load1 = inValid;
    ctl.load2 = v1;
  end

  assign outValid = v2;

  // R7
  stage1_fill_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> v1);

  // R7
  stage1_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !v1);

  // R7
  out_follow_chk: assert property (@(posedge clk) disable iff (rst)
    v1 |=> outValid);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !outValid);

endmodule

// File: rtl/lane_shl_dpath.sv
module lane_shl_dpath
  import lane_shl_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int CNT_W    = 64,
  parameter int IMM_W    = 8,
  parameter int MIN_LANE = 16,
  parameter int NUM_SIZE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  pipeCtl_t         ctl,
  input  logic [VEC_W-1:0] dataIn,
  input  logic [1:0]       laneSel,
  input  logic             wideMode,
  input  logic             useImm,
  input  logic [IMM_W-1:0] immCount,
  input  logic [CNT_W-1:0] regCount,
  output logic [VEC_W-1:0] dataOut
);

  localparam int HALF_W   = VEC_W / 2;
  localparam int MAX_LANE = MIN_LANE << (NUM_SIZE - 1);
  localparam int AMT_W    = $clog2(MAX_LANE);

  // ---------------- stage 1: count select and limit test
  logic [CNT_W-1:0] fullCnt;
  logic [CNT_W-1:0] laneLimit;
  logic             overNext;
  logic [VEC_W-1:0] dataNext;
  laneSel_e         laneNext;

  always_comb begin
    laneNext = laneSel_e'(laneSel);
    fullCnt  = useImm ? CNT_W'(immCount) : regCount;
    case (laneNext)
      LANE16:  laneLimit = CNT_W'(MIN_LANE - 1);
      LANE32:  laneLimit = CNT_W'(2 * MIN_LANE - 1);
      default: laneLimit = CNT_W'(MAX_LANE - 1);
    endcase
    overNext = fullCnt > laneLimit;
    dataNext = wideMode ? dataIn : {{HALF_W{1'b0}}, dataIn[HALF_W-1:0]};
  end

  logic [VEC_W-1:0] s1Data;
  logic [AMT_W-1:0] s1Amt;
  logic             s1Over;
  laneSel_e         s1Lane;
  logic             s1Wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Data <= '0;
      s1Amt  <= '0;
      s1Over <= 1'b0;
      s1Lane <= LANE16;
      s1Wide <= 1'b0;
    end else if (ctl.load1) begin
      s1Data <= dataNext;
      s1Amt  <= fullCnt[AMT_W-1:0];
      s1Over <= overNext;
      s1Lane <= laneNext;
      s1Wide <= wideMode;
    end
  end

  // ---------------- stage 2: per-size lane shifters
  logic [NUM_SIZE-1:0][VEC_W-1:0] shCand;

  for (genvar k = 0; k < NUM_SIZE; k++) begin : g_size
    localparam int LW   = MIN_LANE << k;
    localparam int LBIT = $clog2(LW);
    localparam int NLN  = VEC_W / LW;
    logic [VEC_W-1:0] sizeRes;
    for (genvar i = 0; i < NLN; i++) begin : g_lane
      assign sizeRes[i*LW +: LW] = s1Data[i*LW +: LW] << s1Amt[LBIT-1:0];
    end
    assign shCand[k] = sizeRes;
  end

  logic [VEC_W-1:0] picked;
  logic [VEC_W-1:0] resNext;

  always_comb begin
    case (s1Lane)
      LANE16:  picked = shCand[0];
      LANE32:  picked = shCand[1];
      default: picked = shCand[NUM_SIZE-1];
    endcase
    resNext = s1Over ? '0 : picked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut <= '0;
    end else if (ctl.load2) begin
      dataOut <= resNext;
    end
  end

  // R3
  over_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.load2 && s1Over) |=> (dataOut == '0));

  // R6
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.load2 && !s1Wide) |=> (dataOut[VEC_W-1:HALF_W] == '0));

  // R2
  low_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.load2 && (s1Amt != '0)) |=> (dataOut[0] == 1'b0));

  // R1
  zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.load2 && !s1Over && (s1Amt == '0)) |=> (dataOut == $past(s1Data)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.load2 |=> $stable(dataOut));

endmodule

// File: rtl/lane_shl_unit.sv
module lane_shl_unit
  import lane_shl_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int CNT_W = 64,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [VEC_W-1:0] dataIn,
  input  logic [1:0]       laneSel,
  input  logic             wideMode,
  input  logic             useImm,
  input  logic [IMM_W-1:0] immCount,
  input  logic [CNT_W-1:0] regCount,
  output logic             outValid,
  output logic [VEC_W-1:0] dataOut
);

  pipeCtl_t ctl;

  lane_shl_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  lane_shl_dpath #(
    .VEC_W (VEC_W),
    .CNT_W (CNT_W),
    .IMM_W (IMM_W)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .dataIn   (dataIn),
    .laneSel  (laneSel),
    .wideMode (wideMode),
    .useImm   (useImm),
    .immCount (immCount),
    .regCount (regCount),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/lane_shl_unit_tb.sv
`timescale 1ns/1ps
module lane_shl_unit_tb;

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [127:0] dataIn;
  logic [1:0]   laneSel;
  logic         wideMode;
  logic         useImm;
  logic [7:0]   immCount;
  logic [63:0]  regCount;
  logic         outValid;
  logic [127:0] dataOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  lane_shl_unit u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .dataIn(dataIn),
    .laneSel(laneSel), .wideMode(wideMode), .useImm(useImm),
    .immCount(immCount), .regCount(regCount),
    .outValid(outValid), .dataOut(dataOut)
  );

  function automatic logic [127:0] model(logic [127:0] d, logic [1:0] ls, logic w,
                                         logic ui, logic [7:0] im, logic [63:0] rc);
    logic [63:0]  cnt;
    logic [127:0] src, res, mask, ln;
    int lw;
    cnt = ui ? {56'd0, im} : rc;
    lw  = (ls == 2'b00) ? 16 : (ls == 2'b01) ? 32 : 64;
    src = w ? d : {64'd0, d[63:0]};
    res = '0;
    if (cnt > 64'(lw - 1)) return '0;
    mask = (128'd1 << lw) - 128'd1;
    for (int i = 0; i < 128 / lw; i++) begin
      ln  = (src >> (i * lw)) & mask;
      ln  = (ln << cnt) & mask;
      res = res | (ln << (i * lw));
    end
    return res;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [127:0] d, logic [1:0] ls, logic w, logic ui,
                       logic [7:0] im, logic [63:0] rc);
    inValid = 1'b1; dataIn = d; laneSel = ls; wideMode = w;
    useImm = ui; immCount = im; regCount = rc;
  endtask

  task automatic single(string tag, logic [127:0] d, logic [1:0] ls, logic w,
                        logic ui, logic [7:0] im, logic [63:0] rc);
    logic [127:0] exp;
    exp = model(d, ls, w, ui, im, rc);
    @(negedge clk);
    drive(d, ls, w, ui, im, rc);
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " R7 latency low"}, {127'd0, outValid}, 128'd0);
    @(negedge clk);
    check({tag, " R7 valid"}, {127'd0, outValid}, 128'd1);
    check(tag, dataOut, exp);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog R7 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [127:0] pats [3];
    logic [63:0]  cnts [8];
    logic [127:0] last, dv;
    logic [127:0] expQ [16];
    rst = 1'b1; inValid = 1'b0; dataIn = '0; laneSel = 2'b00;
    wideMode = 1'b1; useImm = 1'b0; immCount = '0; regCount = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 outValid", {127'd0, outValid}, 128'd0);
    check("R9 dataOut", dataOut, 128'd0);
    rst = 1'b0;

    pats[0] = '1;
    pats[1] = {32'hA5C3_9F01, 32'h8000_8001, 32'h1234_5678, 32'hF00F_C33C};
    pats[2] = {$urandom(7), $urandom, $urandom, $urandom};

    for (int ls = 0; ls < 4; ls++) begin
      for (int w = 0; w < 2; w++) begin
        int lw;
        lw = (ls == 0) ? 16 : (ls == 1) ? 32 : 64;
        cnts[0] = 64'd0;
        cnts[1] = 64'd1;
        cnts[2] = 64'(lw - 1);
        cnts[3] = 64'(lw);
        cnts[4] = 64'd255;
        cnts[5] = 64'(lw / 2 + 1);
        cnts[6] = 64'h1_0000_0001;
        cnts[7] = 64'h8000_0000_0000_0003;
        for (int p = 0; p < 3; p++) begin
          for (int c = 0; c < 8; c++) begin
            // R1 R2 R3 R4 R6: register count, full 64-bit compare
            single("R4 reg", pats[p], 2'(ls), 1'(w), 1'b0, 8'h5A, cnts[c]);
            // R5: immediate count, register count is garbage and ignored
            if (c < 6)
              single("R5 imm", pats[p], 2'(ls), 1'(w), 1'b1, cnts[c][7:0],
                     64'h0000_0001_0000_0000 | cnts[c]);
          end
        end
      end
    end

    // R2: a lane's top bit never crosses into the next lane
    single("R2 cross", {8{16'h8000}}, 2'b00, 1'b1, 1'b1, 8'd1, 64'd0);
    // R6: upper input half ignored in narrow mode
    single("R6 narrow", {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, 2'b10, 1'b0, 1'b1, 8'd0, 64'd0);

    // R8: result held while idle
    last = dataOut;
    repeat (3) @(negedge clk);
    check("R8 hold", dataOut, last);

    // R7: back-to-back stream mixing modes
    for (int j = 0; j < 18; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        check("R7 stream valid", {127'd0, outValid}, 128'd1);
        check("R7 stream data", dataOut, expQ[j-2]);
      end
      if (j < 16) begin
        dv = {$urandom, $urandom, $urandom, $urandom};
        expQ[j] = model(dv, 2'(j % 4), 1'(j % 3 != 0), 1'b0, 8'd0, 64'(j * 3));
        drive(dv, 2'(j % 4), 1'(j % 3 != 0), 1'b0, 8'd0, 64'(j * 3));
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    check("R7 stream end", {127'd0, outValid}, 128'd0);

    // R9: reset mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 rerun valid", {127'd0, outValid}, 128'd0);
    check("R9 rerun data", dataOut, 128'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule